// File: doc/BRIEF.md
# Paper feed runaway watchdog

This block supervises every paper advance of a line printer. A start-feed pulse turns on a run flag that releases the brake and engages the clutch. The same pulse arms three timers that count a shared timebase tick: a short fast-charge delay for the brake capacitors, a single-space interval, and a long watchdog of about one second.

A single-space advance ends on its own when the single-space interval runs out. A skip advance ends only when the normal stop input arrives. If the run flag is still set when the watchdog runs out, the block forces the flag off and latches a feed error that halts the printer. Paper travels at 22 inches per second, so one feed can never move more than about 22 inches. The error stays set until the operator clear input is asserted. While it is set, start pulses are ignored.

Top module: `paper_feed_guard`

## Requirements
- R1: After reset, run_o, fast_charge_o, feed_err_o and halt_o are all low.
- R2: A start_feed_i pulse accepted while feed_err_o is low sets run_o at the next clock edge, and run_o stays high until the feed ends.
- R3: When skip_i is 0 at the start (single-space mode), run_o stays high for exactly SPACE_TICKS ticks. It drops at the edge that takes the SPACE_TICKS-th tick after the start cycle.
- R4: When skip_i is 1 at the start (skip mode), the single-space interval does not end the feed. A stop_feed_i pulse ends it at the next edge. stop_feed_i has no effect while no feed is running.
- R5: fast_charge_o rises at the edge that takes the FC_TICKS-th tick after a start, and stays high until the next accepted start clears it.
- R6: If run_o is high at the edge that takes the WD_TICKS-th tick after the last accepted start, feed_err_o is set and run_o is forced low at that same edge. This also holds when stop_feed_i arrives in the same cycle.
- R7: If the watchdog runs out after the feed has already ended, no error is raised.
- R8: A start accepted while a feed is running reloads all three timers. The watchdog window therefore counts from the latest start.
- R9: feed_err_o is sticky and holds run_o low. Start pulses are ignored while it is set, including a start in the same cycle as clear_i. clear_i lowers the error at the next edge.
- R10: Timers advance only on cycles with tick_i high. The start cycle's own tick is not counted.
- R11: halt_o is high exactly when feed_err_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timebase enable |
| start_feed_i | input | 1 | Start-feed pulse |
| skip_i | input | 1 | Mode sampled with start: 0 single-space, 1 skip |
| stop_feed_i | input | 1 | Normal stop for a skip feed |
| clear_i | input | 1 | Operator clear of the feed error |
| run_o | output | 1 | Brake release and clutch engage |
| fast_charge_o | output | 1 | Brake-capacitor fast-charge enable |
| feed_err_o | output | 1 | Latched paper-feed error |
| halt_o | output | 1 | Stop-printer inhibit |

## Verification
Skip feeds are swept over every stop offset from zero to past the watchdog limit. This separates feeds that end cleanly, the boundary where stop and expiry share an edge, and true runaways. Single-space feeds confirm both the self-ending interval and the fast-charge timing, and show that a later watchdog expiry stays silent. Retriggered runs at two offsets show that the watchdog window moves with the latest start. Held-off ticks, starts during an error, and a start in the same cycle as clear show that these inputs have no effect.

// File: rtl/paper_feed_pkg.sv
package paper_feed_pkg;
  typedef enum logic {
    FEED_SPACE = 1'b0,
    FEED_SKIP  = 1'b1
  } feed_mode_e;
endpackage

// File: rtl/pf_tick_timer.sv
module pf_tick_timer #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(TICKS);
  localparam logic [CW-1:0] LAST_VAL = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // a reload masks the expiry it would otherwise coincide with
  assign expire_o = !load_i && tick_i && (cnt_q == LAST_VAL);
endmodule

// File: rtl/pf_run_ctl.sv
module pf_run_ctl
  import paper_feed_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic skip_i,
  input  logic stop_i,
  input  logic clear_i,
  input  logic fc_exp_i,
  input  logic space_exp_i,
  input  logic wd_exp_i,
  output logic run_o,
  output logic fc_o,
  output logic err_o
);
  feed_mode_e mode_q;
  logic run_q, fc_q, err_q;
  logic err_set, run_end;

  assign err_set = wd_exp_i && run_q && !start_i;
  assign run_end = err_set || stop_i || (space_exp_i && mode_q == FEED_SPACE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= FEED_SPACE;
      run_q  <= 1'b0;
      fc_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (start_i) mode_q <= feed_mode_e'(skip_i);

      if (start_i)      run_q <= 1'b1;
      else if (run_end) run_q <= 1'b0;

      if (start_i)       fc_q <= 1'b0;
      else if (fc_exp_i) fc_q <= 1'b1;

      if (err_set)      err_q <= 1'b1;
      else if (clear_i) err_q <= 1'b0;
    end
  end

  assign run_o = run_q;
  assign fc_o  = fc_q;
  assign err_o = err_q;
endmodule

// File: rtl/paper_feed_guard.sv
module paper_feed_guard #(
  parameter int unsigned FC_TICKS    = 3,
  parameter int unsigned SPACE_TICKS = 32,
  parameter int unsigned WD_TICKS    = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_feed_i,
  input  logic skip_i,
  input  logic stop_feed_i,
  input  logic clear_i,
  output logic run_o,
  output logic fast_charge_o,
  output logic feed_err_o,
  output logic halt_o
);
  localparam int NUM_TMR = 3;
  localparam int unsigned TMR_TICKS [NUM_TMR] = '{FC_TICKS, SPACE_TICKS, WD_TICKS};

  logic               start_acc;
  logic [NUM_TMR-1:0] tmr_exp;
  logic               err;

  assign start_acc = start_feed_i && !err;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    pf_tick_timer #(.TICKS(TMR_TICKS[g])) i_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (start_acc),
      .tick_i  (tick_i),
      .expire_o(tmr_exp[g])
    );
  end

  pf_run_ctl i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_acc),
    .skip_i     (skip_i),
    .stop_i     (stop_feed_i),
    .clear_i    (clear_i),
    .fc_exp_i   (tmr_exp[0]),
    .space_exp_i(tmr_exp[1]),
    .wd_exp_i   (tmr_exp[2]),
    .run_o      (run_o),
    .fc_o       (fast_charge_o),
    .err_o      (err)
  );

  assign feed_err_o = err;
  assign halt_o     = err;
endmodule

// File: rtl/pf_guard_chk.sv
module pf_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic start_feed_i,
  input logic stop_feed_i,
  input logic clear_i,
  input logic run_o,
  input logic fast_charge_o,
  input logic feed_err_o,
  input logic halt_o
);
  // R2
  start_sets_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_feed_i && !feed_err_o |=> run_o);
  // R6
  err_kills_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(feed_err_o) |-> !run_o);
  // R9
  err_blocks_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_err_o |-> !run_o);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_err_o && !clear_i |=> feed_err_o);
  // R10
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !start_feed_i && !stop_feed_i && !clear_i |=>
      $stable(run_o) && $stable(fast_charge_o) && $stable(feed_err_o));
  // R11
  halt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o == feed_err_o);
endmodule

bind paper_feed_guard pf_guard_chk i_pf_guard_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .start_feed_i (start_feed_i),
  .stop_feed_i  (stop_feed_i),
  .clear_i      (clear_i),
  .run_o        (run_o),
  .fast_charge_o(fast_charge_o),
  .feed_err_o   (feed_err_o),
  .halt_o       (halt_o)
);

// File: tb/test_paper_feed_guard.sv
module test_paper_feed_guard;
  localparam int CLK_PERIOD = 10;
  localparam int FC = 2;
  localparam int SP = 5;
  localparam int WD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, start = 1'b0, skip = 1'b0, stop = 1'b0, clr = 1'b0;
  logic run, fc, err, halt;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paper_feed_guard #(.FC_TICKS(FC), .SPACE_TICKS(SP), .WD_TICKS(WD)) i_paper_feed_guard (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_feed_i(start), .skip_i(skip),
    .stop_feed_i(stop), .clear_i(clr), .run_o(run), .fast_charge_o(fc),
    .feed_err_o(err), .halt_o(halt));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive start at current negedge; returns at the negedge after its edge
  task automatic do_start(input logic sk);
    start = 1'b1; skip = sk;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    int cnt;
    repeat (2) @(negedge clk);
    // R1
    chk("R1", "run", run, 0); chk("R1", "fc", fc, 0);
    chk("R1", "err", err, 0); chk("R1", "halt", halt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 stop while idle has no effect
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R4", "idle stop run", run, 0); chk("R4", "idle stop err", err, 0);

    // R3 R5 R7 single-space feed, twice (second checks fc clear by start)
    for (int rep = 0; rep < 2; rep++) begin
      do_start(1'b0);
      chk("R2", "run after start", run, 1);
      cnt = 0;
      for (int i = 0; i < WD + 3; i++) begin
        if (run) cnt++;
        if (i < SP + 3) chk("R5", "fast charge", fc, (i >= FC) ? 1 : 0);
        @(negedge clk);
      end
      chk("R3", "space run length", cnt, SP);
      chk("R7", "late expiry err", err, 0);
      chk("R11", "halt", halt, 0);
    end

    // R4 R6 sweep of stop offsets in skip mode
    for (int j = 0; j < WD + 3; j++) begin
      do_start(1'b1);
      cnt = 0;
      for (int i = 0; i < WD + 4; i++) begin
        if (run) cnt++;
        stop = (i == j);
        @(negedge clk);
      end
      stop = 1'b0;
      chk((j + 1 >= WD) ? "R6" : "R4", "skip run length", cnt, (j + 1 < WD) ? j + 1 : WD);
      chk("R6", "err after skip", err, (j + 1 >= WD) ? 1 : 0);
      chk("R11", "halt after skip", halt, (j + 1 >= WD) ? 1 : 0);
      if (err) begin
        // R9 starts ignored while error set
        do_start(1'b1);
        @(negedge clk);
        chk("R9", "start ignored run", run, 0);
        chk("R9", "err sticky", err, 1);
        do_clear();
        chk("R9", "clear err", err, 0);
      end
    end

    // R8 retrigger
    for (int k = 0; k < 2; k++) begin
      int a;
      a = (k == 0) ? 3 : 7;
      do_start(1'b1);
      cnt = 0;
      for (int i = 0; i < a + WD + 4; i++) begin
        if (run) cnt++;
        chk("R8", "fc around retrigger", fc,
            (i <= a) ? ((i >= FC) ? 1 : 0) : ((i >= a + 1 + FC) ? 1 : 0));
        start = (i == a);
        @(negedge clk);
      end
      start = 1'b0;
      chk("R8", "retriggered length", cnt, a + 1 + WD);
      chk("R6", "retrigger runaway err", err, 1);
      // R9 clear and start together: start ignored
      clr = 1'b1; start = 1'b1;
      @(negedge clk);
      clr = 1'b0; start = 1'b0;
      chk("R9", "clear+start err", err, 0);
      chk("R9", "clear+start run", run, 0);
    end

    // R10 ticks gate timers
    tick = 1'b0;
    do_start(1'b0);
    repeat (40) @(negedge clk);
    chk("R10", "run held w/o tick", run, 1);
    chk("R10", "fc held w/o tick", fc, 0);
    chk("R10", "err w/o tick", err, 0);
    tick = 1'b1;
    cnt = 0;
    for (int i = 0; i < SP + 3; i++) begin
      if (run) cnt++;
      @(negedge clk);
    end
    chk("R10", "run length after ticks resume", cnt, SP);

    // R2 start works after clears
    do_start(1'b0);
    chk("R2", "start after clear", run, 1);
    repeat (WD + 2) @(negedge clk);
    chk("R7", "final err", err, 0);
    done = 1'b1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", wd);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule